// File: doc/BRIEF.md
# Linked Pair of 16-Bit Event Counters

This block holds two 16-bit counters, a low channel and a high channel, that either run on their own or join into one 32-bit count. The low channel supplies bits 15:0 and the high channel bits 31:16. Each channel steps on one of two sources, chosen by its own control pins:

- a tick from a shared free-running prescaler, or
- a quadrature (A/B) input pair, when its phase-counting pin is set.

When the high channel's source code is 3'b111 and it is not in phase-counting mode, it steps on the low channel's wraps. A wrap upward from 16'hFFFF adds one to the high channel. A wrap downward from 16'h0000 subtracts one. A downward wrap can only happen when the low channel is in phase-counting mode.

Software loads either counter through a write strobe with data. It reads both counters directly from the count outputs. All control inputs are plain level pins sampled on each rising clock edge. There is no streaming data path, so no valid/ready handshake exists and no back-pressure applies.

Top module: `cascade_counter_pair`

## Requirements
- R1: After reset (active-low `rst_n`, asynchronous), both `lo_count` and `hi_count` read 16'h0000, and the prescaler count is 0.
- R2: Outside phase-counting mode, source codes 0, 1, 2 and 3 step a running channel by +1 on the prescaler tick. The prescaler is a 6-bit counter that advances every cycle from 0 after reset. Code k ticks in the cycles where the prescaler's low 2k bits are all ones, which divides by 1, 4, 16 or 64. Codes 4 to 6 never step. Code 7 never steps the low channel.
- R3: In phase-counting mode, a channel ignores its source code. It steps +1 for each one-bit change that follows the order (A,B) = 00, 10, 11, 01, 00 (A leads B). It steps -1 for each one-bit change in the reverse order. A change of both bits at once is not counted. The inputs pass through two synchronizer flops, so a pin change set up before clock edge k shows on the count output after edge k+2.
- R4: The low channel produces a downward wrap only while its phase-counting pin is set. In prescaler mode it only counts up.
- R5: With the high channel running, not in phase mode, and on source code 3'b111, a low wrap from 16'hFFFF to 16'h0000 adds one to `hi_count` on the same clock edge.
- R6: Under the same high-channel settings, a low wrap from 16'h0000 to 16'hFFFF subtracts one from `hi_count` on the same clock edge.
- R7: With its phase-counting pin set, the high channel counts only its own quadrature pair, even when its source code is 3'b111.
- R8: A channel whose start pin is 0 holds its value. Low wraps that occur while the high channel is stopped are dropped and are not applied later.
- R9: A write strobe loads its counter on the next edge and wins over any count step in that cycle. A load into the low channel never carries or borrows into the high channel.
- R10: With the high channel on any source code other than 3'b111, low wraps have no effect on `hi_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_start | input | 1 | Low channel run enable |
| hi_start | input | 1 | High channel run enable |
| lo_phase_en | input | 1 | Low channel quadrature mode |
| hi_phase_en | input | 1 | High channel quadrature mode |
| lo_clk_sel | input | 3 | Low channel source code |
| hi_clk_sel | input | 3 | High channel source code (3'b111 = low wraps) |
| lo_qa | input | 1 | Low channel quadrature A |
| lo_qb | input | 1 | Low channel quadrature B |
| hi_qa | input | 1 | High channel quadrature A |
| hi_qb | input | 1 | High channel quadrature B |
| wr_lo_en | input | 1 | Load strobe for low counter |
| wr_lo_data | input | 16 | Load value for low counter |
| wr_hi_en | input | 1 | Load strobe for high counter |
| wr_hi_data | input | 16 | Load value for high counter |
| lo_count | output | 16 | Low counter value |
| hi_count | output | 16 | High counter value |

## Verification
The hardest case to reach from the ports is a borrow across the 32-bit boundary. It needs the low channel in phase mode, sitting at zero, and then a single reverse-order quadrature step, all while the high channel is chained. The stimulus loads the low counter with a small value and then walks the quadrature pair backward one Gray state at a time. It leaves three cycles between steps so that each step clears the synchronizer before the next. Load-versus-wrap priority is reached with back-to-back loads, so that a load lands in the very cycle the low counter holds 16'hFFFF.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int CNT_W   = 16;
  localparam int SEL_W   = 3;
  localparam int NUM_DIV = 4;
  localparam int PRE_W   = 2 * (NUM_DIV - 1);
  localparam logic [SEL_W-1:0] SEL_CHAIN = 3'b111;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;
endpackage

// File: rtl/cpc_prescaler.sv
module cpc_prescaler
  import cpc_pkg::*;
#(
  parameter int N_DIV = NUM_DIV,
  parameter int PW    = 2 * (N_DIV - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [N_DIV-1:0] tick
);
  logic [PW-1:0] pre_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;
  end

  for (genvar i = 0; i < N_DIV; i++) begin : g_tick
    if (i == 0) begin : g_always
      assign tick[i] = 1'b1;
    end else begin : g_masked
      assign tick[i] = &pre_cnt[2*i-1:0];
    end
  end
endmodule

// File: rtl/cpc_quad_decoder.sv
module cpc_quad_decoder
  import cpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  qa,
  input  logic  qb,
  output step_t step
);
  logic [1:0] sync1, sync2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= {qa, qb};
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_comb begin
    step = '0;
    case ({prev, sync2})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: step.up = 1'b1;
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: step.dn = 1'b1;
      default: step = '0;
    endcase
  end
endmodule

// File: rtl/cpc_channel.sv
module cpc_channel
  import cpc_pkg::*;
#(
  parameter int W        = CNT_W,
  parameter int SW       = SEL_W,
  parameter int N_DIV    = NUM_DIV,
  parameter bit IS_UPPER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             phase_en,
  input  logic [SW-1:0]    sel,
  input  logic [N_DIV-1:0] div_tick,
  input  step_t            quad,
  input  step_t            chain,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     count,
  output step_t            wrap
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic  sel_tick;
  step_t chain_src;
  step_t move;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < N_DIV; i++) begin
      if (sel == SW'(i)) sel_tick = div_tick[i];
    end
  end

  if (IS_UPPER) begin : g_chain
    assign chain_src = (sel == SEL_CHAIN) ? chain : '0;
  end else begin : g_no_chain
    assign chain_src = '0;
  end

  always_comb begin
    move = '0;
    if (start && !wr_en) begin
      if (phase_en)                         move = quad;
      else if (IS_UPPER && sel == SEL_CHAIN) move = chain_src;
      else                                   move.up = sel_tick;
    end
  end

  assign wrap.up = move.up && (count == ALL_ONES);
  assign wrap.dn = move.dn && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (wr_en)   count <= wr_data;
    else if (move.up) count <= count + 1'b1;
    else if (move.dn) count <= count - 1'b1;
  end
endmodule

// File: rtl/cascade_counter_pair.sv
module cascade_counter_pair
  import cpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_start,
  input  logic             hi_start,
  input  logic             lo_phase_en,
  input  logic             hi_phase_en,
  input  logic [SEL_W-1:0] lo_clk_sel,
  input  logic [SEL_W-1:0] hi_clk_sel,
  input  logic             lo_qa,
  input  logic             lo_qb,
  input  logic             hi_qa,
  input  logic             hi_qb,
  input  logic             wr_lo_en,
  input  logic [CNT_W-1:0] wr_lo_data,
  input  logic             wr_hi_en,
  input  logic [CNT_W-1:0] wr_hi_data,
  output logic [CNT_W-1:0] lo_count,
  output logic [CNT_W-1:0] hi_count
);
  logic [NUM_DIV-1:0] div_tick;
  step_t lo_quad, hi_quad, lo_wrap, hi_wrap;
  logic  lo_wrap_up, lo_wrap_dn;

  cpc_prescaler #(.N_DIV(NUM_DIV), .PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(div_tick)
  );

  cpc_quad_decoder u_lo_q (
    .clk(clk), .rst_n(rst_n), .qa(lo_qa), .qb(lo_qb), .step(lo_quad)
  );

  cpc_quad_decoder u_hi_q (
    .clk(clk), .rst_n(rst_n), .qa(hi_qa), .qb(hi_qb), .step(hi_quad)
  );

  cpc_channel #(.IS_UPPER(1'b0)) u_lo (
    .clk(clk), .rst_n(rst_n), .start(lo_start), .phase_en(lo_phase_en),
    .sel(lo_clk_sel), .div_tick(div_tick), .quad(lo_quad), .chain('0),
    .wr_en(wr_lo_en), .wr_data(wr_lo_data), .count(lo_count), .wrap(lo_wrap)
  );

  cpc_channel #(.IS_UPPER(1'b1)) u_hi (
    .clk(clk), .rst_n(rst_n), .start(hi_start), .phase_en(hi_phase_en),
    .sel(hi_clk_sel), .div_tick(div_tick), .quad(hi_quad), .chain(lo_wrap),
    .wr_en(wr_hi_en), .wr_data(wr_hi_data), .count(hi_count), .wrap(hi_wrap)
  );

  assign lo_wrap_up = lo_wrap.up;
  assign lo_wrap_dn = lo_wrap.dn;
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        lo_start,
  input logic        hi_start,
  input logic        lo_phase_en,
  input logic        hi_phase_en,
  input logic [2:0]  hi_clk_sel,
  input logic        wr_lo_en,
  input logic [15:0] wr_lo_data,
  input logic        wr_hi_en,
  input logic [15:0] lo_count,
  input logic [15:0] hi_count,
  input logic        lo_wrap_up,
  input logic        lo_wrap_dn
);
  logic chained;
  assign chained = hi_start && !hi_phase_en && (hi_clk_sel == 3'b111) && !wr_hi_en;

  assert_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wrap_up && chained) |=> (hi_count == $past(hi_count) + 16'd1));

  assert_lo_wraps_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap_up |=> (lo_count == 16'h0000));

  assert_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wrap_dn && chained) |=> (hi_count == $past(hi_count) - 16'd1));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap_dn |-> lo_phase_en);

  assert_lo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_start && !wr_lo_en) |=> $stable(lo_count));

  assert_hi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_start && !wr_hi_en) |=> $stable(hi_count));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_en |=> (lo_count == $past(wr_lo_data)));

  assert_load_no_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_en && chained) |=> $stable(hi_count));
endmodule

bind cascade_counter_pair cpc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lo_start(lo_start), .hi_start(hi_start),
  .lo_phase_en(lo_phase_en), .hi_phase_en(hi_phase_en), .hi_clk_sel(hi_clk_sel),
  .wr_lo_en(wr_lo_en), .wr_lo_data(wr_lo_data), .wr_hi_en(wr_hi_en),
  .lo_count(lo_count), .hi_count(hi_count),
  .lo_wrap_up(lo_wrap_up), .lo_wrap_dn(lo_wrap_dn)
);

// File: tb/sim_cascade_counter_pair.sv
`timescale 1ns/1ps
module sim_cascade_counter_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_start = 0, hi_start = 0, lo_phase_en = 0, hi_phase_en = 0;
  logic [2:0] lo_clk_sel = 0, hi_clk_sel = 0;
  logic lo_qa = 0, lo_qb = 0, hi_qa = 0, hi_qb = 0;
  logic wr_lo_en = 0, wr_hi_en = 0;
  logic [15:0] wr_lo_data = 0, wr_hi_data = 0;
  logic [15:0] lo_count, hi_count;

  int checks = 0, failures = 0, wd = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  cascade_counter_pair u0 (.*);

  // behavioural reference
  logic [15:0] m_lo = 0, m_hi = 0;
  logic [1:0]  ms1 [2], ms2 [2], mprev [2];
  int pc = 0;

  function automatic int gidx(input logic [1:0] v);
    case (v)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int qdir(input logic [1:0] p, input logic [1:0] c);
    int d;
    d = (gidx(c) - gidx(p) + 4) % 4;
    if (d == 1) return 1;
    if (d == 3) return -1;
    return 0;
  endfunction

  function automatic bit ptick(input logic [2:0] sel, input int pcv);
    int dv;
    if (sel > 3'd3) return 1'b0;
    dv = 1 << (2 * int'(sel));
    return (pcv % dv) == dv - 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; pc = 0;
      for (int i = 0; i < 2; i++) begin ms1[i] = 0; ms2[i] = 0; mprev[i] = 0; end
    end else begin
      int s_lo, s_hi, ev;
      s_lo = 0; s_hi = 0; ev = 0;
      if (!wr_lo_en && lo_start) begin
        if (lo_phase_en) s_lo = qdir(mprev[0], ms2[0]);
        else if (ptick(lo_clk_sel, pc)) s_lo = 1;
      end
      if (s_lo == 1 && m_lo == 16'hFFFF) ev = 1;
      if (s_lo == -1 && m_lo == 16'h0000) ev = -1;
      if (!wr_hi_en && hi_start) begin
        if (hi_phase_en) s_hi = qdir(mprev[1], ms2[1]);
        else if (hi_clk_sel == 3'b111) s_hi = ev;
        else if (ptick(hi_clk_sel, pc)) s_hi = 1;
      end
      m_lo = wr_lo_en ? wr_lo_data : m_lo + 16'(s_lo);
      m_hi = wr_hi_en ? wr_hi_data : m_hi + 16'(s_hi);
      for (int i = 0; i < 2; i++) begin mprev[i] = ms2[i]; ms2[i] = ms1[i]; end
      ms1[0] = {lo_qa, lo_qb};
      ms1[1] = {hi_qa, hi_qb};
      pc = (pc + 1) % 64;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " lo"}, lo_count, m_lo);
      chk({cur_req, " hi"}, hi_count, m_hi);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_lo(input logic [15:0] v);
    wr_lo_en = 1; wr_lo_data = v; cyc(1); wr_lo_en = 0;
  endtask

  task automatic load_hi(input logic [15:0] v);
    wr_hi_en = 1; wr_hi_data = v; cyc(1); wr_hi_en = 0;
  endtask

  int qi [2] = '{0, 0};
  function automatic logic [1:0] gray(input int i);
    case (i)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic qstep(input int ch, input int dir, input int n);
    for (int k = 0; k < n; k++) begin
      qi[ch] = (qi[ch] + dir + 4) % 4;
      if (ch == 0) {lo_qa, lo_qb} = gray(qi[ch]);
      else         {hi_qa, hi_qb} = gray(qi[ch]);
      cyc(3);
    end
  endtask

  initial begin
    cyc(4);
    cur_req = "R1";
    chk("R1 lo reset", lo_count, 16'h0000);
    chk("R1 hi reset", hi_count, 16'h0000);
    rst_n = 1;
    cyc(2);

    // R2: prescaler divides and no-count codes on low channel
    cur_req = "R2";
    lo_start = 1;
    lo_clk_sel = 3'd0; cyc(20);
    lo_clk_sel = 3'd1; cyc(40);
    lo_clk_sel = 3'd2; cyc(80);
    lo_clk_sel = 3'd3; cyc(200);
    lo_clk_sel = 3'd5; cyc(30);
    lo_clk_sel = 3'd7; cyc(30);

    // R3: quadrature on low channel, incl. illegal double change
    cur_req = "R3";
    lo_phase_en = 1;
    qstep(0, 1, 10);
    qstep(0, -1, 13);
    {lo_qa, lo_qb} = ~{lo_qa, lo_qb}; qi[0] = (qi[0] + 2) % 4; cyc(4);
    qstep(0, 1, 2);

    // R6: borrow through zero into chained high channel
    cur_req = "R6";
    hi_clk_sel = 3'b111; hi_start = 1;
    load_hi(16'h0010);
    load_lo(16'h0002);
    qstep(0, -1, 5);
    chk("R6 borrow", hi_count, 16'h000F);
    cur_req = "R5";
    qstep(0, 1, 5);
    chk("R5 carry by phase", hi_count, 16'h0010);

    // R4/R5: prescaled low channel overflow
    cur_req = "R4";
    lo_phase_en = 0; lo_clk_sel = 3'd0;
    load_lo(16'hFFF0);
    cyc(20);
    chk("R5 carry by prescaler", hi_count, 16'h0011);

    // R8: stopped high channel drops wraps
    cur_req = "R8";
    hi_start = 0;
    load_lo(16'hFFF8);
    cyc(20);
    hi_start = 1; cyc(3);
    chk("R8 no queued carry", hi_count, 16'h0011);
    lo_start = 0; cyc(10);
    lo_start = 1;

    // R9: load priority and no carry from a load
    cur_req = "R9";
    load_lo(16'hFFFF);
    load_lo(16'h1234);
    chk("R9 no carry on load", hi_count, 16'h0011);
    load_lo(16'hFFFF);
    load_hi(16'h5555);
    chk("R9 hi load wins", hi_count, 16'h5555);
    cyc(5);

    // R10: independent channels when not chained
    cur_req = "R10";
    hi_clk_sel = 3'd0; load_lo(16'hFFFC); cyc(20);
    hi_clk_sel = 3'd2; load_lo(16'hFFF0); cyc(40);
    hi_clk_sel = 3'd6; load_lo(16'hFFF0); cyc(30);

    // R7: high channel in phase mode ignores chain code
    cur_req = "R7";
    hi_clk_sel = 3'b111; hi_phase_en = 1;
    load_hi(16'h0100);
    load_lo(16'hFFF0);
    qstep(1, 1, 3);
    qstep(1, -1, 1);
    cyc(20);
    chk("R7 own quadrature only", hi_count, 16'h0102);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule